// File: doc/BRIEF.md
# Packed-Lane Saturating Multimedia ALU

This block is the arithmetic core of a SIMD execute stage. Its three 128-bit source operands arrive already resolved, and it returns a single 128-bit result. The operands are handled as packed lanes.

Halfword operations split the data into eight signed 16-bit lanes. Each lane is computed on its own and clamped on its own. The unsigned add splits the data into four 32-bit lanes, and each lane wraps with no carry into its neighbour. Two three-operand forms multiply the signed low halfwords of each 32-bit lane and then accumulate into, or subtract from, a 32-bit lane of the first source. The result of these forms is clamped to the signed 32-bit range. A load-immediate operation places a 16-bit constant into one chosen halfword and keeps the other halfwords of the old destination value, which is supplied on the first source.

The operation code is already decoded when it reaches the block. The result is registered, so it appears one clock after the inputs are applied.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_i` is high at a rising edge, `result_o` becomes zero. Otherwise `result_o` takes the value computed from the inputs sampled at that edge, so the latency is one cycle and the output holds between edges.
- R2: When `op_i` = 0 (halfword add), each 16-bit lane k (bits 16k+15:16k) of the result is the signed sum of the matching lanes of `src1_i` and `src2_i`. Lanes do not affect each other.
- R3: When `op_i` = 0 and a lane sum leaves the signed 16-bit range, that lane becomes 0x7FFF on positive overflow and 0x8000 on negative overflow.
- R4: When `op_i` = 1 (halfword subtract), each 16-bit lane is `src1_i` lane minus `src2_i` lane, clamped to 0x7FFF or 0x8000 in the same way.
- R5: When `op_i` = 2 (unsigned word add), each 32-bit lane is the sum of the matching lanes of `src1_i` and `src2_i` modulo 2^32. There is no saturation and no carry between lanes.
- R6: When `op_i` = 3, the result is the bitwise AND of `src1_i` and `src2_i` over all 128 bits. When `op_i` = 4, it is the bitwise OR.
- R7: When `op_i` = 5 (load immediate), halfword `ld_idx_i` (bits 16i+15:16i) of the result equals `imm_i`. The other seven halfwords equal those of `src1_i`.
- R8: When `op_i` = 6, each 32-bit lane k is `src1_i` lane k plus the signed product of the low halfwords (bits 32k+15:32k) of `src2_i` and `src3_i`. When `op_i` = 7, the product is subtracted instead. The upper halfwords of `src2_i` and `src3_i` have no effect.
- R9: When `op_i` = 6 or 7 and the 32-bit lane result overflows, that lane becomes 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Decoded operation code |
| src1_i | input | 128 | First source operand; accumulator, or old destination for load immediate |
| src2_i | input | 128 | Second source operand |
| src3_i | input | 128 | Third source operand (multiply forms only) |
| imm_i | input | 16 | Immediate value for load immediate |
| ld_idx_i | input | 3 | Halfword slot written by load immediate |
| result_o | output | 128 | Registered result |

## Verification
The properties assume that every input holds a known value at each rising edge once reset is released. They also assume that reset is held for at least one edge before operation starts. The 3-bit operation code has no illegal values, so any driven code is valid. The stimulus changes all inputs only on falling edges and never leaves a bit undriven. It keeps reset high from time zero through the first edges, so every `$past` term that a property reads refers to a defined cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_HADD_SAT = 3'd0,
    OP_HSUB_SAT = 3'd1,
    OP_WADD_U   = 3'd2,
    OP_AND      = 3'd3,
    OP_OR       = 3'd4,
    OP_LOAD_IMM = 3'd5,
    OP_MUL_ADD  = 3'd6,
    OP_MUL_SUB  = 3'd7
  } alu_op_e;

endpackage

// File: rtl/sat_addsub.sv
// One signed lane: add or subtract with clamping on overflow.
module sat_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W-1:0] raw;
  logic         ovf;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    raw   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    ovf   = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
    y_o   = ovf ? (a_i[W-1] ? MAX_NEG : MAX_POS) : raw;
  end
endmodule

// File: rtl/halfword_sat_lanes.sv
// Packed signed lanes, each clamped independently.
module halfword_sat_lanes #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sat_addsub #(.W(LANE_W)) u_lane (
      .a_i  (a_i[k*LANE_W +: LANE_W]),
      .b_i  (b_i[k*LANE_W +: LANE_W]),
      .sub_i(sub_i),
      .y_o  (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/word_wrap_lanes.sv
// Packed unsigned lanes that wrap, with no carry between lanes.
module word_wrap_lanes #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign y_o[k*LANE_W +: LANE_W] = a_i[k*LANE_W +: LANE_W] + b_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/mac_sat_lanes.sv
// Per word lane: acc +/- (signed low half of m1 * signed low half of m2), saturated.
module mac_sat_lanes #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] m1_i,
  input  logic [DATA_W-1:0] m2_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int HW    = LANE_W / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [HW-1:0]     fa;
    logic signed [HW-1:0]     fb;
    logic signed [LANE_W-1:0] prod;

    assign fa   = m1_i[k*LANE_W +: HW];
    assign fb   = m2_i[k*LANE_W +: HW];
    assign prod = fa * fb;

    sat_addsub #(.W(LANE_W)) u_acc (
      .a_i  (acc_i[k*LANE_W +: LANE_W]),
      .b_i  (prod),
      .sub_i(sub_i),
      .y_o  (y_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HALF_W = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DATA_W / HALF_W)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] src3_i,
  input  logic [HALF_W-1:0] imm_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int HLANES = DATA_W / HALF_W;

  alu_op_e           op;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] mac_res;
  logic [DATA_W-1:0] li_res;
  logic [DATA_W-1:0] next_res;

  assign op = alu_op_e'(op_i);

  halfword_sat_lanes #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_half (
    .a_i  (src1_i),
    .b_i  (src2_i),
    .sub_i(op == OP_HSUB_SAT),
    .y_o  (half_res)
  );

  word_wrap_lanes #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_word (
    .a_i(src1_i),
    .b_i(src2_i),
    .y_o(word_res)
  );

  mac_sat_lanes #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_mac (
    .acc_i(src1_i),
    .m1_i (src2_i),
    .m2_i (src3_i),
    .sub_i(op == OP_MUL_SUB),
    .y_o  (mac_res)
  );

  for (genvar k = 0; k < HLANES; k++) begin : g_li
    assign li_res[k*HALF_W +: HALF_W] =
      (ld_idx_i == IDX_W'(k)) ? imm_i : src1_i[k*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (op)
      OP_HADD_SAT, OP_HSUB_SAT: next_res = half_res;
      OP_WADD_U:                next_res = word_res;
      OP_AND:                   next_res = src1_i & src2_i;
      OP_OR:                    next_res = src1_i | src2_i;
      OP_LOAD_IMM:              next_res = li_res;
      OP_MUL_ADD, OP_MUL_SUB:   next_res = mac_res;
      default:                  next_res = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) result_o <= '0;
    else       result_o <= next_res;
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DATA_W = 128,
  parameter int HALF_W = 16,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src1_i,
  input logic [DATA_W-1:0] src2_i,
  input logic [DATA_W-1:0] src3_i,
  input logic [HALF_W-1:0] imm_i,
  input logic [IDX_W-1:0]  ld_idx_i,
  input logic [DATA_W-1:0] result_o
);
  localparam int HLANES = DATA_W / HALF_W;

  // R1: a reset edge leaves a zero result
  p_reset_zero_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> result_o == '0);

  // R3: a clamped halfword lane keeps the sign shared by both inputs
  for (genvar k = 0; k < HLANES; k++) begin : g_ahs
    localparam int S = k*HALF_W + HALF_W - 1;
    p_sign_pos_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(op_i) == 3'd0 && !$past(src1_i[S]) && !$past(src2_i[S]))
        |-> !result_o[S]);
    p_sign_neg_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(op_i) == 3'd0 && $past(src1_i[S]) && $past(src2_i[S]))
        |-> result_o[S]);
  end

  // R5: lowest word lane wraps modulo 2^32
  p_word_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 3'd2)
      |-> result_o[WORD_W-1:0] == WORD_W'($past(src1_i[WORD_W-1:0]) + $past(src2_i[WORD_W-1:0])));

  // R6: bitwise forms over all bits
  p_and_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 3'd3) |-> result_o == ($past(src1_i) & $past(src2_i)));
  p_or_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 3'd4) |-> result_o == ($past(src1_i) | $past(src2_i)));

  // R7: the selected halfword carries the immediate
  p_li_slot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 3'd5)
      |-> result_o[$past(ld_idx_i)*HALF_W +: HALF_W] == $past(imm_i));

  // R9: accumulate of a non-negative lane with a non-negative product stays non-negative
  p_mac_sat_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(op_i) == 3'd6 && !$past(src1_i[WORD_W-1])
      && ($past(src2_i[HALF_W-1]) == $past(src3_i[HALF_W-1])))
      |-> !result_o[WORD_W-1]);
endmodule

bind simd_sat_alu simd_sat_alu_chk #(
  .DATA_W(DATA_W), .HALF_W(HALF_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .op_i(op_i), .src1_i(src1_i), .src2_i(src2_i),
  .src3_i(src3_i), .imm_i(imm_i), .ld_idx_i(ld_idx_i), .result_o(result_o)
);

// File: tb/test_simd_sat_alu.sv
module test_simd_sat_alu;
  typedef struct packed {
    logic [2:0]   op;
    logic [2:0]   idx;
    logic [15:0]  imm;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
    logic [127:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'h0, {4{16'h0001,16'h1234}}, {4{16'h0002,16'hFFFF}}, 128'h0, {4{16'h0003,16'h1233}}, 4'd2},
    '{3'd0, 3'd0, 16'h0, {8{16'h7000}}, {8{16'h2000}}, 128'h0, {8{16'h7FFF}}, 4'd3},
    '{3'd0, 3'd0, 16'h0, {8{16'h8000}}, {8{16'hFFFF}}, 128'h0, {8{16'h8000}}, 4'd3},
    '{3'd0, 3'd0, 16'h0, {4{16'h7FFF,16'h0100}}, {4{16'h0001,16'h0100}}, 128'h0, {4{16'h7FFF,16'h0200}}, 4'd3},
    '{3'd1, 3'd0, 16'h0, {8{16'h0005}}, {8{16'h0007}}, 128'h0, {8{16'hFFFE}}, 4'd4},
    '{3'd1, 3'd0, 16'h0, {8{16'h8000}}, {8{16'h0001}}, 128'h0, {8{16'h8000}}, 4'd4},
    '{3'd1, 3'd0, 16'h0, {8{16'h7FFF}}, {8{16'hFFFF}}, 128'h0, {8{16'h7FFF}}, 4'd4},
    '{3'd2, 3'd0, 16'h0, {4{32'hFFFFFFFF}}, {4{32'h00000001}}, 128'h0, 128'h0, 4'd5},
    '{3'd2, 3'd0, 16'h0, {4{32'h7FFFFFFF}}, {4{32'h00000001}}, 128'h0, {4{32'h80000000}}, 4'd5},
    '{3'd3, 3'd0, 16'h0, {4{32'hF0F01234}}, {4{32'hFF00FFFF}}, 128'h0, {4{32'hF0001234}}, 4'd6},
    '{3'd4, 3'd0, 16'h0, {4{32'hF0F01234}}, {4{32'hFF00FFFF}}, 128'h0, {4{32'hFFF0FFFF}}, 4'd6},
    '{3'd5, 3'd3, 16'h1234, {8{16'hAAAA}}, {8{16'h5555}}, 128'h0, {{4{16'hAAAA}},16'h1234,{3{16'hAAAA}}}, 4'd7},
    '{3'd5, 3'd0, 16'hBEEF, {8{16'hAAAA}}, 128'h0, 128'h0, {{7{16'hAAAA}},16'hBEEF}, 4'd7},
    '{3'd5, 3'd7, 16'hBEEF, {8{16'hAAAA}}, 128'h0, 128'h0, {16'hBEEF,{7{16'hAAAA}}}, 4'd7},
    '{3'd6, 3'd0, 16'h0, {4{32'h00000010}}, {4{16'hFFFF,16'h0003}}, {4{16'h5555,16'hFFFE}}, {4{32'h0000000A}}, 4'd8},
    '{3'd7, 3'd0, 16'h0, {4{32'h00000064}}, {4{16'h1111,16'hFFFD}}, {4{16'h2222,16'h0005}}, {4{32'h00000073}}, 4'd8},
    '{3'd6, 3'd0, 16'h0, {4{32'h7FFFFFF0}}, {4{16'h0000,16'h7FFF}}, {4{16'h0000,16'h7FFF}}, {4{32'h7FFFFFFF}}, 4'd9},
    '{3'd7, 3'd0, 16'h0, {4{32'h80000010}}, {4{16'h0000,16'h7FFF}}, {4{16'h0000,16'h7FFF}}, {4{32'h80000000}}, 4'd9}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op = '0;
  logic [127:0] s1 = '0, s2 = '0, s3 = '0;
  logic [15:0]  imm = '0;
  logic [2:0]   idx = '0;
  logic [127:0] res;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  simd_sat_alu i_simd_sat_alu (
    .clk_i(clk), .rst_i(rst), .op_i(op), .src1_i(s1), .src2_i(s2), .src3_i(s3),
    .imm_i(imm), .ld_idx_i(idx), .result_o(res)
  );

  function automatic string req_name(logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic [2:0] i, logic [15:0] m,
                       logic [127:0] a, logic [127:0] b, logic [127:0] c);
    op = o; idx = i; imm = m; s1 = a; s2 = b; s3 = c;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with busy inputs applied
    drive(3'd4, 3'd0, 16'h0, {128{1'b1}}, 128'h0, 128'h0);
    repeat (3) @(negedge clk);
    check("R1", res, 128'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].op, VECS[v].idx, VECS[v].imm, VECS[v].a, VECS[v].b, VECS[v].c);
      @(negedge clk);
      check(req_name(VECS[v].req), res, VECS[v].exp);
    end

    // R1: output holds between edges, new value one edge later
    drive(3'd3, 3'd0, 16'h0, {128{1'b1}}, {4{32'h0000FFFF}}, 128'h0);
    #5;
    check("R1", res, {4{32'h80000000}});
    @(negedge clk);
    check("R1", res, {4{32'h0000FFFF}});

    // R8: most negative halfword squared, upper halves ignored
    drive(3'd6, 3'd0, 16'h0, 128'h0, {4{16'h1234,16'h8000}}, {4{16'hFEDC,16'h8000}});
    @(negedge clk);
    check("R8", res, {4{32'h40000000}});

    // R7: load immediate into each slot in turn
    for (int k = 0; k < 8; k++) begin
      logic [127:0] e;
      e = {8{16'h3C3C}};
      e[k*16 +: 16] = 16'h9A5F;
      drive(3'd5, 3'(k), 16'h9A5F, {8{16'h3C3C}}, {8{16'hFFFF}}, {8{16'hFFFF}});
      @(negedge clk);
      check("R7", res, e);
    end

    // R1: reset mid-stream clears a non-zero result
    drive(3'd4, 3'd0, 16'h0, {4{32'h12345678}}, 128'h0, 128'h0);
    @(negedge clk);
    check("R6", res, {4{32'h12345678}});
    rst = 1'b1;
    @(negedge clk);
    check("R1", res, 128'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule